// File: doc/BRIEF.md
# Protected Watchdog Timer Controller

This block is the watchdog of a small microcontroller. A 16-bit counter advances on a slow tick enable (nominally 32.768 kHz) and, unless software services it in time, the block either pulses a one-cycle system reset or raises an interrupt request. Software reaches it through one 8-bit control register. The fields are: a 4-bit timeout select in bits [7:4], an interrupt-mode bit in bit 3, a sticky timeout flag in bit 2, an enable/service bit in bit 1 and an unlock bit in bit 0. Bit 0 always reads back as 0.

Two writes are needed to change anything in the register. The first write, with bit 0 set, arms the register, and its data is thrown away. A write in the very next clock cycle is then committed. A cycle without a write disarms the register again. A lock input forces the interrupt-mode bit to read 0 and the enable bit to read 1, so a locked watchdog always resets and can never be switched off. Select codes 8 and 9 request an immediate reset, and code 9 also strobes a serial-download request. The block's own reset puts the configuration back to its power-up values but keeps the timeout flag. Software can therefore tell a watchdog reset from an external one.

The unlock machine has two states. `U_IDLE` goes to `U_ARMED` on a write with bit 0 set. `U_ARMED` returns to `U_IDLE` on any cycle, and commits the data if that cycle carries a write. The event machine has three states. `E_RUN` goes to `E_RST` on an immediate-reset code, or on a timeout in reset mode. It goes to `E_IRQ` on a timeout in interrupt mode. `E_RST` lasts one cycle and returns to `E_RUN`, restoring the defaults. `E_IRQ` goes back to `E_RUN` once the flag is clear. It goes to `E_RST` on an immediate code, or on a timeout after the mode has turned to reset.

Top module: `wdog_ctrl`

## Requirements
- R1: After the external reset `rst_n` the register reads 0x72: select 7, interrupt mode 0, flag 0, enable 1. All three event outputs are low.
- R2: With select code k in 0..7, a timeout occurs 2^(k+9) ticks after the counter was last cleared. A committed write with bit 1 set clears the counter.
- R3: Counting from the release of the external reset, the watchdog times out after 65536 ticks with no software action.
- R4: A committed write with bit 1 clear, made while the lock is off, disables the watchdog. No event occurs while it stays disabled.
- R5: A timeout in reset mode (bit 3 = 0) drives `sys_rst_o` high for exactly one clock cycle. Afterwards select is 7, interrupt mode is 0 and enable is 1.
- R6: The flag (bit 2) is set by every timeout and by every immediate reset. It is cleared by a committed write with bit 2 = 0 or by `rst_n`. The block's own reset does not clear it.
- R7: A timeout in interrupt mode (bit 3 = 1) raises `irq_o` instead of a reset. `irq_o` stays high until the flag is cleared and falls one cycle after the clearing write.
- R8: A write takes effect only when it directly follows an arming write (bit 0 = 1). Writes that are not armed, and writes made after a cycle without a write, change nothing. The data of the arming write is discarded.
- R9: Committing select 8 gives a `sys_rst_o` pulse in the cycle after the commit edge. Select 9 does the same and raises `dl_req_o` alongside the reset pulse.
- R10: Select codes 10 to 15 time out after 65536 ticks, like code 7, and read back as written.
- R11: While `lock_i` is high, bit 3 reads 0 and bit 1 reads 1. Timeouts give a reset. A committed write with bit 1 = 0 does not disable the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous |
| tick | input | 1 | One-cycle counting enable from the slow timebase |
| lock_i | input | 1 | Protection lock: forces reset mode with the watchdog enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sys_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Watchdog interrupt request, held |
| dl_req_o | output | 1 | Serial-download request strobe, coincident with the reset pulse |

## Verification
The assertions take for granted that `lock_i` does not change in the cycle where a timeout selects between interrupt and reset. They also take for granted that `reg_wr` is low in the cycle after reset release, since the unarmed-write property looks one cycle back. The bench changes the lock only while the counter is far from its limit. It drives all bus activity at the falling edge, with the write strobe idle between sequences. Expected event cycles are derived from the cycle of the commit edge, so every timeout is predicted before it can occur.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    parameter int unsigned REG_W          = 8;
    parameter int unsigned SEL_W          = 4;
    parameter int unsigned SEL_LAST_TIMED = 7;
    parameter int unsigned SEL_IMM        = 8;
    parameter int unsigned SEL_DL         = 9;
    parameter int unsigned SEL_DEFAULT    = 7;

    // bit positions inside the control register
    parameter int unsigned B_UNLOCK = 0;
    parameter int unsigned B_RUN    = 1;
    parameter int unsigned B_FLAG   = 2;
    parameter int unsigned B_IRQ    = 3;
    parameter int unsigned B_SEL    = 4;

    typedef enum logic {
        U_IDLE,
        U_ARMED
    } unlock_e;

    typedef enum logic [1:0] {
        E_RUN,
        E_RST,
        E_IRQ
    } event_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             irq_mode;
        logic             flag;
        logic             run;
    } cfg_t;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             lock_i,
    input  logic             soft_rst,
    input  logic             flag_set,
    output logic             commit,
    output logic             kick,
    output logic [SEL_W-1:0] sel,
    output logic             irq_mode_eff,
    output logic             run_eff,
    output logic             flag,
    output logic [REG_W-1:0] rdata
);

    unlock_e state_q, state_d;
    cfg_t    cfg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
        end else if (soft_rst) begin
            state_q <= U_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and commit strobe
    always_comb begin
        state_d = U_IDLE;
        commit  = 1'b0;
        unique case (state_q)
            U_IDLE: begin
                if (reg_wr && reg_wdata[B_UNLOCK]) begin
                    state_d = U_ARMED;
                end
            end
            U_ARMED: begin
                commit  = reg_wr;
                state_d = U_IDLE;
            end
            default: state_d = U_IDLE;
        endcase
    end

    assign kick = commit && reg_wdata[B_RUN];

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel      <= SEL_W'(SEL_DEFAULT);
            cfg_q.irq_mode <= 1'b0;
            cfg_q.flag     <= 1'b0;
            cfg_q.run      <= 1'b1;
        end else if (soft_rst) begin
            cfg_q.sel      <= SEL_W'(SEL_DEFAULT);
            cfg_q.irq_mode <= 1'b0;
            cfg_q.run      <= 1'b1;
        end else begin
            if (commit) begin
                cfg_q.sel <= reg_wdata[B_SEL +: SEL_W];
                if (!lock_i) begin
                    cfg_q.irq_mode <= reg_wdata[B_IRQ];
                    cfg_q.run      <= reg_wdata[B_RUN];
                end
            end
            if (flag_set) begin
                cfg_q.flag <= 1'b1;
            end else if (commit && !reg_wdata[B_FLAG]) begin
                cfg_q.flag <= 1'b0;
            end
        end
    end

    assign sel          = cfg_q.sel;
    assign flag         = cfg_q.flag;
    assign irq_mode_eff = cfg_q.irq_mode && !lock_i;
    assign run_eff      = cfg_q.run || lock_i;

    always_comb begin
        rdata                   = '0;
        rdata[B_SEL +: SEL_W]   = cfg_q.sel;
        rdata[B_IRQ]            = irq_mode_eff;
        rdata[B_FLAG]           = cfg_q.flag;
        rdata[B_RUN]            = run_eff;
        rdata[B_UNLOCK]         = 1'b0;
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned BASE_SHIFT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             kick,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int unsigned N_SEL = 1 << SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_tab [N_SEL];

    // last count value before timeout, one entry per select code;
    // codes above the last timed one reuse its period
    for (genvar g = 0; g < N_SEL; g++) begin : g_last
        localparam int unsigned      EFF  = (g <= SEL_LAST_TIMED) ? g : SEL_LAST_TIMED;
        localparam int unsigned      SH   = BASE_SHIFT + EFF;
        localparam logic [CNT_W:0]   FULL = {{CNT_W{1'b0}}, 1'b1} << SH;
        assign last_tab[g] = FULL[CNT_W-1:0] - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick || restart || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = en && tick && !kick && (cnt_q == last_tab[sel]);

endmodule

// File: rtl/wdog_event.sv
module wdog_event
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             irq_mode_eff,
    input  logic             commit,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             flag,
    output logic             flag_set,
    output logic             soft_rst,
    output logic             sys_rst_o,
    output logic             irq_o,
    output logic             dl_req_o
);

    event_e state_q, state_d;
    logic   dl_q;
    logic   imm, imm_dl;

    assign imm_dl = commit && (wr_sel == SEL_W'(SEL_DL));
    assign imm    = imm_dl || (commit && (wr_sel == SEL_W'(SEL_IMM)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_RUN;
            dl_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            dl_q    <= (state_q != E_RST) && imm_dl;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_RUN: begin
                if (imm) begin
                    state_d = E_RST;
                end else if (expire) begin
                    state_d = irq_mode_eff ? E_IRQ : E_RST;
                end
            end
            E_RST: begin
                state_d = E_RUN;
            end
            E_IRQ: begin
                if (imm) begin
                    state_d = E_RST;
                end else if (expire) begin
                    state_d = irq_mode_eff ? E_IRQ : E_RST;
                end else if (!flag) begin
                    state_d = E_RUN;
                end
            end
            default: state_d = E_RUN;
        endcase
    end

    assign flag_set = (state_q != E_RST) && (imm || expire);
    assign soft_rst = (state_q == E_RST);

    // outputs
    always_comb begin
        sys_rst_o = 1'b0;
        irq_o     = 1'b0;
        dl_req_o  = 1'b0;
        unique case (state_q)
            E_RUN: ;
            E_RST: begin
                sys_rst_o = 1'b1;
                dl_req_o  = dl_q;
            end
            E_IRQ: irq_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned BASE_SHIFT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lock_i,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sys_rst_o,
    output logic             irq_o,
    output logic             dl_req_o
);

    logic             commit, kick;
    logic [SEL_W-1:0] sel;
    logic             irq_mode_eff, run_eff, flag;
    logic             flag_set, soft_rst, expire;

    wdog_unlock u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .lock_i       (lock_i),
        .soft_rst     (soft_rst),
        .flag_set     (flag_set),
        .commit       (commit),
        .kick         (kick),
        .sel          (sel),
        .irq_mode_eff (irq_mode_eff),
        .run_eff      (run_eff),
        .flag         (flag),
        .rdata        (reg_rdata)
    );

    wdog_count #(
        .CNT_W      (CNT_W),
        .BASE_SHIFT (BASE_SHIFT)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (run_eff),
        .kick    (kick),
        .restart (flag_set || soft_rst),
        .sel     (sel),
        .expire  (expire)
    );

    wdog_event u_event (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .irq_mode_eff (irq_mode_eff),
        .commit       (commit),
        .wr_sel       (reg_wdata[B_SEL +: SEL_W]),
        .flag         (flag),
        .flag_set     (flag_set),
        .soft_rst     (soft_rst),
        .sys_rst_o    (sys_rst_o),
        .irq_o        (irq_o),
        .dl_req_o     (dl_req_o)
    );

endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lock_i,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       sys_rst_o,
    input logic       irq_o,
    input logic       dl_req_o
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o); // R5

    AST_DEFAULTS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (reg_rdata[7:4] == 4'd7 && reg_rdata[1] && !reg_rdata[3])); // R5

    AST_FLAG_ON_RST: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> reg_rdata[2]); // R6

    AST_RST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_o && irq_o)); // R7

    AST_FLAG_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> reg_rdata[2]); // R7

    AST_UNARMED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !$past(reg_wr) && !sys_rst_o) |=> $stable(reg_rdata[7:4])); // R8

    AST_DL_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        dl_req_o |-> sys_rst_o); // R9

    AST_LOCK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |-> (!reg_rdata[3] && reg_rdata[1])); // R11

endmodule

bind wdog_ctrl wdog_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_i),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .sys_rst_o (sys_rst_o),
    .irq_o     (irq_o),
    .dl_req_o  (dl_req_o)
);

// File: tb/tb_wdog_ctrl.sv
`timescale 1ns/1ps
module tb_wdog_ctrl;

    localparam int K_RST = 0;
    localparam int K_DL  = 1;
    localparam int K_IRQ = 2;

    logic       clk = 1'b0;
    logic       rst_n, tick, lock_i, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sys_rst_o, irq_o, dl_req_o;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    int events = 0;

    int    q_kind[$];
    int    q_cyc[$];
    string q_req[$];

    wdog_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .lock_i    (lock_i),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_rst_o (sys_rst_o),
        .irq_o     (irq_o),
        .dl_req_o  (dl_req_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push(input int kind, input int at, input string req);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
        q_req.push_back(req);
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // arm then commit; commit edge is two edges after the first negedge
    task automatic commit_exp(input logic [7:0] d, input int kind, input int ofs, input string req);
        @(negedge clk);
        if (kind >= 0) push(kind, cyc + 2 + ofs, req);
        reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drain(input int maxc, input string req);
        for (int i = 0; i < maxc && q_kind.size() != 0; i++) @(negedge clk);
        checks++;
        if (q_kind.size() != 0) begin
            errs++;
            $display("FAIL %s actual=no event expected=event by cycle %0d", req, q_cyc[0]);
            q_kind.delete(); q_cyc.delete(); q_req.delete();
        end
        repeat (2) @(negedge clk);
    endtask

    // monitor side of the scoreboard
    logic prev_rst = 1'b0, prev_irq = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sys_rst_o && prev_rst) begin
                checks++; errs++;
                $display("FAIL R5 actual=reset wider than one cycle expected=one cycle");
            end
            if (dl_req_o && !sys_rst_o) begin
                checks++; errs++;
                $display("FAIL R9 actual=download without reset expected=with reset");
            end
            if ((sys_rst_o && !prev_rst) || (irq_o && !prev_irq)) begin
                int kact;
                kact = irq_o ? K_IRQ : (dl_req_o ? K_DL : K_RST);
                events++;
                checks++;
                if (q_kind.size() == 0) begin
                    errs++;
                    $display("FAIL R4 actual=event %0d at cycle %0d expected=none", kact, cyc);
                end else begin
                    int    ek, ec;
                    string er;
                    ek = q_kind.pop_front();
                    ec = q_cyc.pop_front();
                    er = q_req.pop_front();
                    if (ek != kact || ec != cyc) begin
                        errs++;
                        $display("FAIL %s actual=kind %0d cycle %0d expected=kind %0d cycle %0d",
                                 er, kact, cyc, ek, ec);
                    end
                end
            end
        end
        prev_rst <= sys_rst_o && rst_n;
        prev_irq <= irq_o && rst_n;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        int ev0, k;
        rst_n = 1'b0; tick = 1'b1; lock_i = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset value", reg_rdata, 8'h72);
        chk("R1 outputs idle", {sys_rst_o, irq_o, dl_req_o}, 0);

        // R3: unattended timeout after reset release
        rst_n = 1'b1;
        push(K_RST, cyc + 65536, "R3");
        drain(70000, "R3");
        chk("R6 flag kept, R5 defaults", reg_rdata, 8'h76);

        // R8: unarmed write, then armed write followed by a gap
        bus_wr(8'h02);
        @(negedge clk);
        chk("R8 unarmed write ignored", reg_rdata, 8'h76);
        bus_wr(8'hF1);
        chk("R8 arming data discarded", reg_rdata, 8'h76);
        bus_wr(8'h02);
        @(negedge clk);
        chk("R8 gap disarms", reg_rdata, 8'h76);

        // R2 / R6: select 0, clear flag, then service it once
        commit_exp(8'h02, -1, 0, "");
        chk("R6 flag cleared by write", reg_rdata, 8'h02);
        repeat (300) @(negedge clk);
        commit_exp(8'h02, K_RST, 512, "R2 kick restarts");
        drain(700, "R2");
        chk("R5 defaults after reset", reg_rdata, 8'h76);
        commit_exp(8'h12, K_RST, 1024, "R2 select 1");
        drain(1200, "R2");

        // R7: interrupt mode
        commit_exp(8'h0A, K_IRQ, 512, "R7 interrupt timeout");
        drain(700, "R7");
        chk("R7 flag with interrupt", reg_rdata, 8'h0E);
        repeat (700) @(negedge clk);
        chk("R7 interrupt held", irq_o, 1);
        commit_exp(8'h0A, K_IRQ, 512, "R7 second interrupt");
        @(negedge clk);
        chk("R7 interrupt released", irq_o, 0);
        drain(700, "R7");

        // R4: clear flag and disable
        commit_exp(8'h08, -1, 0, "");
        @(negedge clk);
        chk("R4 disabled readback", reg_rdata, 8'h08);
        ev0 = events;
        repeat (2000) @(negedge clk);
        chk("R4 no event while disabled", events, ev0);
        chk("R4 outputs quiet", {sys_rst_o, irq_o}, 0);

        // R9: immediate resets
        commit_exp(8'h82, K_RST, 0, "R9 immediate");
        drain(10, "R9");
        chk("R9 defaults after immediate", reg_rdata, 8'h76);
        commit_exp(8'h92, K_DL, 0, "R9 download");
        drain(10, "R9");

        // R10: reserved select code
        commit_exp(8'hC2, K_RST, 65536, "R10 reserved period");
        chk("R10 readback", reg_rdata, 8'hC2);
        drain(70000, "R10");

        // R11: lock
        lock_i = 1'b1;
        @(negedge clk);
        chk("R11 locked read", reg_rdata, 8'h76);
        commit_exp(8'h08, -1, 0, "");
        chk("R11 cannot disable or set interrupt", reg_rdata, 8'h02);
        commit_exp(8'h0A, K_RST, 512, "R11 forced reset mode");
        drain(700, "R11");
        lock_i = 1'b0;
        @(negedge clk);
        chk("R11 unlocked defaults", reg_rdata, 8'h76);

        // R6: external reset clears the flag
        k = 0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 flag cleared by rst_n", reg_rdata, 8'h72);
        chk("R1 idle after rst_n", {sys_rst_o, irq_o, dl_req_o}, k);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule